// File: doc/BRIEF.md
# SCSI Target Selection Detector

This block watches the filtered target-side bus lines: SEL, BSY, I/O, RST, the eight data lines and the data parity bit. It decides when the device is being selected as a target. Each data line stands for one target ID. A per-ID enable mask decides which of those IDs the device answers to. The selection condition must hold without a break for a qualification window before it is accepted. The window is 43 clocks in normal mode and 5 clocks in fast-latch mode. Once the block accepts a selection, it latches a selected flag and the index of the winning ID, and it emits a one-clock event pulse.

The selected flag stays set after the initiator lets go of SEL. Some initiators drop SEL a few hundred nanoseconds later without waiting for BSY, so the flag cannot track the line. The block also keeps a sticky flag for a bus reset seen on RST, and that flag raises the same event pulse. Software clears each flag with its own write-one-to-clear strobe. An optional odd-parity check can reject an ID byte that arrives with bad parity. A bypass control turns off the single-clock glitch filter on the inputs.

Top module: `scsiSelDetect`

## Requirements
- R1: A selection is accepted only while SEL is high, BSY is low, I/O is low, RST is low and at least one data line whose mask bit is set is high.
- R2: With an all-zero ID mask no selection is ever accepted.
- R3: The condition of R1 must hold for FAST_CNT (default 5) consecutive clocks when fastLatch is 1, or for SLOW_CNT (default 43) consecutive clocks when it is 0. A shorter hold accepts nothing.
- R4: Once set, `selected` and `selectedId` hold their values after SEL drops and while other valid selections appear. They clear only on a `clrSelected` pulse or on block reset.
- R5: When several enabled IDs are present at once, `selectedId` is the highest bit index among them, as a 3-bit binary number.
- R6: `eventOut` is high for exactly one clock each time `selected` sets or `busResetFlag` sets. Each such rise gives one pulse.
- R7: RST held high sets the sticky `busResetFlag`. The flag stays set after RST drops and clears only on a `clrBusReset` pulse or on block reset.
- R8: With parityEn at 1, a selection is ignored unless the XOR of the eight data lines and parityIn is 1 (odd parity). With parityEn at 0, parityIn has no effect.
- R9: With filterBypass at 0, an input level that lasts only one clock is ignored. With filterBypass at 1, such a level is passed through, so a one-clock RST pulse sets `busResetFlag`.
- R10: After block reset, `selected`, `selectedId`, `busResetFlag` and `eventOut` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Active-low block reset |
| selIn | input | 1 | Bus SEL, active high |
| bsyIn | input | 1 | Bus BSY, active high |
| ioIn | input | 1 | Bus I/O, active high |
| busRstIn | input | 1 | Bus RST, active high |
| dataIn | input | 8 | Bus data lines; bit n means target ID n |
| parityIn | input | 1 | Bus data parity bit |
| idMask | input | 8 | Per-ID response enable |
| fastLatch | input | 1 | Selects the short qualification window |
| parityEn | input | 1 | Enables the odd-parity check on the ID byte |
| filterBypass | input | 1 | Turns off the one-clock glitch filter |
| clrSelected | input | 1 | Write-one-to-clear strobe for `selected` |
| clrBusReset | input | 1 | Write-one-to-clear strobe for `busResetFlag` |
| selected | output | 1 | Sticky selected status |
| selectedId | output | 3 | Index of the accepted ID |
| busResetFlag | output | 1 | Sticky bus-reset status |
| eventOut | output | 1 | One-clock event on a flag rise |

## Verification
The random patterns draw mask and data bytes, BSY, I/O, parity and parity-enable values at random, so IDs present with no mask bit can be told apart from real selections. Cases with several enabled IDs at once check the highest-index choice, and good or bad parity is checked with the check both on and off. Directed cases hold a valid pattern just shorter and well longer than each window, which separates the fast count from the normal count. Another case offers a second selection while the first is still latched, to show the latched ID does not move. One-clock RST pulses with the filter on and off show whether the glitch filter is active. A held RST confirms the reset flag is sticky and can be cleared.

// File: rtl/scsiSelPkg.sv
package scsiSelPkg;
  typedef struct packed {
    logic setSel;
    logic setRst;
    logic clrSel;
    logic clrRst;
  } selStrobes_t;
endpackage

// File: rtl/selDatapath.sv
module selDatapath
  import scsiSelPkg::*;
#(
  parameter int IDS  = 8,
  parameter int ID_W = $clog2(IDS)
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            selIn,
  input  logic            bsyIn,
  input  logic            ioIn,
  input  logic            busRstIn,
  input  logic [IDS-1:0]  dataIn,
  input  logic            parityIn,
  input  logic [IDS-1:0]  idMask,
  input  logic            parityEn,
  input  logic            filterBypass,
  input  selStrobes_t     strobes,
  output logic            condOk,
  output logic            busRstSeen,
  output logic            selectedQ,
  output logic [ID_W-1:0] selIdQ,
  output logic            busRstQ,
  output logic            evtQ
);
  localparam int NB    = IDS + 5;
  localparam int B_PAR = IDS;
  localparam int B_SEL = IDS + 1;
  localparam int B_BSY = IDS + 2;
  localparam int B_IO  = IDS + 3;
  localparam int B_RST = IDS + 4;

  logic [NB-1:0] rawVec;
  logic [NB-1:0] filtVec;
  assign rawVec = {busRstIn, ioIn, bsyIn, selIn, parityIn, dataIn};

  // One filter cell per input line: a level passes once two samples agree
  for (genvar i = 0; i < NB; i++) begin : g_filt
    logic smp, prv, flt;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        smp <= 1'b0;
        prv <= 1'b0;
        flt <= 1'b0;
      end else begin
        smp <= rawVec[i];
        prv <= smp;
        if (filterBypass || (smp == prv)) flt <= smp;
      end
    end
    assign filtVec[i] = flt;
  end

  logic [IDS-1:0]  filtData, hitVec;
  logic            filtSel, filtBsy, filtIo, filtRst, filtPar, parityOk;
  logic [ID_W-1:0] winId;

  assign filtData = filtVec[IDS-1:0];
  assign filtPar  = filtVec[B_PAR];
  assign filtSel  = filtVec[B_SEL];
  assign filtBsy  = filtVec[B_BSY];
  assign filtIo   = filtVec[B_IO];
  assign filtRst  = filtVec[B_RST];
  assign hitVec   = filtData & idMask;
  assign parityOk = ^{filtData, filtPar};

  // Highest enabled ID wins
  always_comb begin
    winId = '0;
    for (int k = 0; k < IDS; k++) begin
      if (hitVec[k]) winId = ID_W'(k);
    end
  end

  assign condOk = filtSel && !filtBsy && !filtIo && !filtRst && (|hitVec)
                  && (!parityEn || parityOk);
  assign busRstSeen = filtRst;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      selectedQ <= 1'b0;
      selIdQ    <= '0;
      busRstQ   <= 1'b0;
      evtQ      <= 1'b0;
    end else begin
      if (strobes.setSel) begin
        selectedQ <= 1'b1;
        selIdQ    <= winId;
      end else if (strobes.clrSel) begin
        selectedQ <= 1'b0;
        selIdQ    <= '0;
      end
      if (strobes.setRst)      busRstQ <= 1'b1;
      else if (strobes.clrRst) busRstQ <= 1'b0;
      evtQ <= strobes.setSel | (strobes.setRst & !busRstQ);
    end
  end

  p_sel_sticky_r4: assert property (@(posedge clk) disable iff (!rstN)
    (selectedQ && !strobes.clrSel) |=> selectedQ);
  p_id_stable_r4: assert property (@(posedge clk) disable iff (!rstN)
    (selectedQ && !strobes.clrSel) |=> $stable(selIdQ));
  p_bus_ok_r1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(selectedQ) |-> ($past(filtSel) && !$past(filtBsy) && !$past(filtIo)));
  p_mask_r2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(selectedQ) |-> $past(|idMask));
  p_parity_r8: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(selectedQ) && $past(parityEn)) |-> $past(parityOk));
  p_evt_sel_r6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(selectedQ) |-> evtQ);
  p_evt_rst_r6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busRstQ) |-> evtQ);
  p_rst_sticky_r7: assert property (@(posedge clk) disable iff (!rstN)
    (busRstQ && !strobes.clrRst) |=> busRstQ);
endmodule

// File: rtl/selControl.sv
module selControl
  import scsiSelPkg::*;
#(
  parameter int SLOW_CNT = 43,
  parameter int FAST_CNT = 5
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        condOk,
  input  logic        busRstSeen,
  input  logic        selectedQ,
  input  logic        fastLatch,
  input  logic        clrSelected,
  input  logic        clrBusReset,
  output selStrobes_t strobes
);
  localparam int CNT_W = $clog2(SLOW_CNT + 1);
  localparam logic [CNT_W-1:0] SLOW_LAST = CNT_W'(SLOW_CNT - 1);
  localparam logic [CNT_W-1:0] FAST_LAST = CNT_W'(FAST_CNT - 1);

  logic [CNT_W-1:0] holdCnt;
  logic [CNT_W-1:0] lastCnt;
  logic             reached;

  assign lastCnt = fastLatch ? FAST_LAST : SLOW_LAST;
  assign reached = holdCnt >= lastCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                     holdCnt <= '0;
    else if (!condOk || selectedQ) holdCnt <= '0;
    else if (!reached)             holdCnt <= holdCnt + 1'b1;
  end

  always_comb begin
    strobes.setSel = condOk && !selectedQ && reached;
    strobes.setRst = busRstSeen;
    strobes.clrSel = clrSelected;
    strobes.clrRst = clrBusReset;
  end

  p_cnt_bound_r3: assert property (@(posedge clk) disable iff (!rstN)
    holdCnt <= SLOW_LAST);
  p_qual_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    (holdCnt != '0) |-> $past(condOk));
endmodule

// File: rtl/scsiSelDetect.sv
module scsiSelDetect
  import scsiSelPkg::*;
#(
  parameter int IDS      = 8,
  parameter int SLOW_CNT = 43,
  parameter int FAST_CNT = 5,
  localparam int ID_W    = $clog2(IDS)
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            selIn,
  input  logic            bsyIn,
  input  logic            ioIn,
  input  logic            busRstIn,
  input  logic [IDS-1:0]  dataIn,
  input  logic            parityIn,
  input  logic [IDS-1:0]  idMask,
  input  logic            fastLatch,
  input  logic            parityEn,
  input  logic            filterBypass,
  input  logic            clrSelected,
  input  logic            clrBusReset,
  output logic            selected,
  output logic [ID_W-1:0] selectedId,
  output logic            busResetFlag,
  output logic            eventOut
);
  selStrobes_t strobes;
  logic        condOk, busRstSeen;

  selDatapath #(.IDS(IDS), .ID_W(ID_W)) u_dp (
    .clk(clk), .rstN(rstN), .selIn(selIn), .bsyIn(bsyIn), .ioIn(ioIn),
    .busRstIn(busRstIn), .dataIn(dataIn), .parityIn(parityIn),
    .idMask(idMask), .parityEn(parityEn), .filterBypass(filterBypass),
    .strobes(strobes), .condOk(condOk), .busRstSeen(busRstSeen),
    .selectedQ(selected), .selIdQ(selectedId), .busRstQ(busResetFlag),
    .evtQ(eventOut)
  );

  selControl #(.SLOW_CNT(SLOW_CNT), .FAST_CNT(FAST_CNT)) u_ctl (
    .clk(clk), .rstN(rstN), .condOk(condOk), .busRstSeen(busRstSeen),
    .selectedQ(selected), .fastLatch(fastLatch), .clrSelected(clrSelected),
    .clrBusReset(clrBusReset), .strobes(strobes)
  );
endmodule

// File: tb/test_scsiSelDetect.sv
module test_scsiSelDetect;
  localparam int CLK_PERIOD = 10;
  localparam int SLOW = 43;
  localparam int FAST = 5;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic selIn = 0, bsyIn = 0, ioIn = 0, busRstIn = 0, parityIn = 0;
  logic [7:0] dataIn = 0, idMask = 0;
  logic fastLatch = 0, parityEn = 0, filterBypass = 0;
  logic clrSelected = 0, clrBusReset = 0;
  logic selected, busResetFlag, eventOut;
  logic [2:0] selectedId;

  int total = 0;
  int fails = 0;
  int evtCnt = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) if (eventOut) evtCnt++;

  scsiSelDetect i_scsiSelDetect (
    .clk(clk), .rstN(rstN), .selIn(selIn), .bsyIn(bsyIn), .ioIn(ioIn),
    .busRstIn(busRstIn), .dataIn(dataIn), .parityIn(parityIn),
    .idMask(idMask), .fastLatch(fastLatch), .parityEn(parityEn),
    .filterBypass(filterBypass), .clrSelected(clrSelected),
    .clrBusReset(clrBusReset), .selected(selected),
    .selectedId(selectedId), .busResetFlag(busResetFlag),
    .eventOut(eventOut)
  );

  function automatic bit expSel(logic [7:0] d, logic [7:0] m, logic p,
                                logic b, logic io, logic pe);
    return !b && !io && ((d & m) != 0) && (!pe || (^{d, p}));
  endfunction

  function automatic int expId(logic [7:0] d, logic [7:0] m);
    int r = 0;
    for (int k = 0; k < 8; k++) if (d[k] & m[k]) r = k;
    return r;
  endfunction

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(bit ok, string req, int act, int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idleBus();
    selIn = 0; bsyIn = 0; ioIn = 0; busRstIn = 0; dataIn = 0; parityIn = 0;
  endtask

  task automatic clearSel();
    clrSelected = 1; cyc(1); clrSelected = 0; cyc(2);
  endtask

  task automatic clearRst();
    clrBusReset = 1; cyc(1); clrBusReset = 0; cyc(2);
  endtask

  task automatic summary();
    $display("  %0d/%0d checks passed", total - fails, total);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      total++; fails++;
      $display("FAIL watchdog expired");
      summary();
    end
  end

  initial begin
    int base;
    void'($urandom(1234));
    cyc(3);
    // R10 reset state
    chk(!selected && !busResetFlag && !eventOut && selectedId == 0, "R10 reset",
        {selected, busResetFlag, eventOut}, 0);
    rstN = 1;
    cyc(2);

    // R3 fast window: short hold rejected, long hold accepted
    fastLatch = 1; idMask = 8'h08; dataIn = 8'h08; selIn = 1;
    cyc(FAST - 3); idleBus(); cyc(4);
    chk(!selected, "R3 fast short hold", selected, 0);
    dataIn = 8'h08; selIn = 1; cyc(FAST + 4);
    chk(selected && selectedId == 3, "R3 fast long hold", selectedId, 3);

    // R4 a later valid selection leaves the latched ID alone
    base = evtCnt;
    idleBus(); cyc(3);
    idMask = 8'hFF; dataIn = 8'h40; selIn = 1; cyc(FAST + 6);
    chk(selectedId == 3 && selected, "R4 id held", selectedId, 3);
    chk(evtCnt == base, "R4 no new event", evtCnt, base);
    idleBus(); clearSel();
    chk(!selected, "R4 clear", selected, 0);

    // R3 slow window
    fastLatch = 0; idMask = 8'h01; dataIn = 8'h01; selIn = 1;
    cyc(SLOW - 3); idleBus(); cyc(4);
    chk(!selected, "R3 slow short hold", selected, 0);
    dataIn = 8'h01; selIn = 1; cyc(SLOW + 6);
    chk(selected && selectedId == 0, "R3 slow long hold", selectedId, 0);
    idleBus(); clearSel();

    // R2 zero mask
    fastLatch = 1; idMask = 8'h00; dataIn = 8'hFF; selIn = 1; cyc(FAST + 8);
    chk(!selected, "R2 zero mask", selected, 0);
    idleBus(); cyc(2);

    // R5 several enabled IDs
    idMask = 8'h25; dataIn = 8'hA5; selIn = 1; cyc(FAST + 6);
    chk(selected && selectedId == 5, "R5 highest id", selectedId, 5);
    idleBus(); clearSel();

    // R7 bus reset sticky flag and event
    base = evtCnt;
    busRstIn = 1; cyc(4); busRstIn = 0; cyc(4);
    chk(busResetFlag, "R7 sticky reset", busResetFlag, 1);
    chk(evtCnt == base + 1, "R6 reset event", evtCnt, base + 1);
    clearRst();
    chk(!busResetFlag, "R7 clear", busResetFlag, 0);

    // R9 glitch filter
    filterBypass = 0; busRstIn = 1; cyc(1); busRstIn = 0; cyc(4);
    chk(!busResetFlag, "R9 glitch rejected", busResetFlag, 0);
    filterBypass = 1; busRstIn = 1; cyc(1); busRstIn = 0; cyc(4);
    chk(busResetFlag, "R9 bypass passes", busResetFlag, 1);
    clearRst(); filterBypass = 0;

    // R1 R8 R6 R4 random patterns
    for (int it = 0; it < 80; it++) begin
      logic [7:0] d, m;
      logic p, b, io, pe, fl;
      bit e;
      int b0;
      d = 8'($urandom); m = 8'($urandom);
      p = 1'($urandom); pe = 1'($urandom); fl = 1'($urandom);
      b = ($urandom % 4 == 0); io = ($urandom % 8 == 0);
      e = expSel(d, m, p, b, io, pe);
      b0 = evtCnt;
      fastLatch = fl; parityEn = pe; idMask = m;
      dataIn = d; parityIn = p; bsyIn = b; ioIn = io; selIn = 1;
      cyc(SLOW + 8);
      chk(selected == e, "R1 R8 select decision", selected, e);
      if (e) chk(selectedId == 3'(expId(d, m)), "R5 random id", selectedId, expId(d, m));
      idleBus(); cyc(4);
      chk(selected == e, "R4 sticky after SEL drop", selected, e);
      chk(evtCnt == b0 + int'(e), "R6 event count", evtCnt, b0 + int'(e));
      clearSel();
      chk(!selected, "R4 cleared", selected, 0);
    end

    finished = 1;
    summary();
  end
endmodule